// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block runs the complete erase of one block of a parallel NOR flash that uses the extended command set. A single start strobe and a block address launch it. It raises the program-voltage enable and issues the two-write erase command to the block. It then reads the status byte from the same address until the ready bit appears or a time budget runs out. Once polling ends it drops the program voltage, writes the clear-status command and finally the read-array command, so the device is left readable.

The last status byte read is decoded into four separate error flags: block locked, low program voltage, program failure and erase failure. Running out of time sets a fifth flag of its own. All five flags hold until the next accepted start. The time budget is given in milliseconds and converted to clock cycles by a parameter. The caller guarantees that the address lies on a block boundary.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, busy, done, progVoltEn, busWe, busRe and all five error flags are low.
- R2: A start sampled while idle raises busy and progVoltEn in the next cycle. The block then writes 0x20 and, in the following cycle, 0xD0 to the block address, both with progVoltEn high.
- R3: Polling alternates a one-cycle read request (busRe) at the block address with an evaluation cycle in which busRdata is examined. Bit 7 set means ready. If the first ready byte is returned by read number k (counting from 0), done is high in the cycle after clock edge 2k+6, where edge 0 is the edge that sampled start.
- R4: When polling ends, progVoltEn drops. The block then writes 0x50 and, in the next cycle, 0xFF to the block address. After that, done is high for exactly one cycle, with busy already low.
- R5: The last status byte read sets errLock from bit 1, errVolt from bit 3, errProg from bit 4 and errErase from bit 5. The flags hold after done and are cleared in the cycle after the next accepted start.
- R6: If ready has not been seen once TIMEOUT_MS × CYC_PER_MS cycles have elapsed since start, errTimeout is set. The clear-status and read-array writes still follow. Done never comes earlier than that cycle budget.
- R7: A start pulse while busy is ignored: the sequence timing and the bus address do not change.
- R8: busWe and busRe are never high together, and both are low whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch an erase (accepted only when idle) |
| blockAddr | input | ADDR_W | Address of the block to erase |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| errLock | output | 1 | Status reported block locked |
| errVolt | output | 1 | Status reported low program voltage |
| errProg | output | 1 | Status reported program failure |
| errErase | output | 1 | Status reported erase failure |
| errTimeout | output | 1 | Ready not seen within the time budget |
| progVoltEn | output | 1 | Program-voltage enable |
| busAddr | output | ADDR_W | Flash bus address |
| busWe | output | 1 | Flash bus write strobe |
| busRe | output | 1 | Flash bus read strobe |
| busWdata | output | DATA_W | Flash bus write data |
| busRdata | input | DATA_W | Flash bus read data, valid in the cycle after busRe |

## Verification
The erase is run first against a device that is ready on its first status read and then against one that needs several reads. The exact done cycle in each case separates a correct poll loop from one that exits early or adds extra cycles. Each status error bit is then returned on its own and all together, which catches swapped or merged flag decoding. A device that never becomes ready exercises the timeout path and shows that the cleanup writes still happen. A second start injected in mid-poll with a different address must leave both the timing and the address untouched.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD_ERASE, S_CMD_CONFIRM, S_POLL_REQ,
    S_POLL_EVAL, S_CLR_STAT, S_READ_ARRAY, S_FINISH
  } seqState_t;

  typedef enum logic [1:0] {
    OP_ERASE, OP_CONFIRM, OP_CLEAR, OP_READARRAY
  } busOp_t;

  typedef struct packed {
    logic   loadAddr;
    logic   clearFlags;
    logic   captureStatus;
    logic   flagTimeout;
    logic   pvOn;
    logic   pvOff;
    busOp_t op;
  } seqCtl_t;

  localparam logic [7:0] CMD_ERASE     = 8'h20;
  localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
  localparam logic [7:0] CMD_CLEAR     = 8'h50;
  localparam logic [7:0] CMD_READARRAY = 8'hFF;

  localparam int BIT_LOCK  = 1;
  localparam int BIT_VOLT  = 3;
  localparam int BIT_PROG  = 4;
  localparam int BIT_ERASE = 5;
  localparam int BIT_READY = 7;

endpackage

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
  import erase_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    statusReady,
  input  logic    timerExpired,
  output seqCtl_t ctl,
  output logic    busWe,
  output logic    busRe,
  output logic    busy,
  output logic    done
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    ctl.op    = OP_ERASE;
    busWe     = 1'b0;
    busRe     = 1'b0;
    done      = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          ctl.loadAddr   = 1'b1;
          ctl.clearFlags = 1'b1;
          ctl.pvOn       = 1'b1;
          nextState      = S_CMD_ERASE;
        end
      end
      S_CMD_ERASE: begin
        busWe     = 1'b1;
        ctl.op    = OP_ERASE;
        nextState = S_CMD_CONFIRM;
      end
      S_CMD_CONFIRM: begin
        busWe     = 1'b1;
        ctl.op    = OP_CONFIRM;
        nextState = S_POLL_REQ;
      end
      S_POLL_REQ: begin
        busRe     = 1'b1;
        nextState = S_POLL_EVAL;
      end
      S_POLL_EVAL: begin
        if (statusReady) begin
          ctl.captureStatus = 1'b1;
          ctl.pvOff         = 1'b1;
          nextState         = S_CLR_STAT;
        end else if (timerExpired) begin
          ctl.captureStatus = 1'b1;
          ctl.flagTimeout   = 1'b1;
          ctl.pvOff         = 1'b1;
          nextState         = S_CLR_STAT;
        end else begin
          nextState = S_POLL_REQ;
        end
      end
      S_CLR_STAT: begin
        busWe     = 1'b1;
        ctl.op    = OP_CLEAR;
        nextState = S_READ_ARRAY;
      end
      S_READ_ARRAY: begin
        busWe     = 1'b1;
        ctl.op    = OP_READARRAY;
        nextState = S_FINISH;
      end
      S_FINISH: begin
        done      = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE) && (state != S_FINISH);

endmodule

// File: rtl/erase_seq_datapath.sv
module erase_seq_datapath
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 8,
  parameter int CYC_PER_MS = 100000,
  parameter int TIMEOUT_MS = 1500
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] blockAddr,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              progVoltEn,
  output logic              statusReady,
  output logic              timerExpired,
  output logic              errLock,
  output logic              errVolt,
  output logic              errProg,
  output logic              errErase,
  output logic              errTimeout
);

  localparam longint LIMIT   = longint'(CYC_PER_MS) * longint'(TIMEOUT_MS);
  localparam int     TIMER_W = $clog2(LIMIT + 1);
  localparam logic [TIMER_W-1:0] LIMIT_V = TIMER_W'(LIMIT);

  logic [ADDR_W-1:0]  addrQ;
  logic [TIMER_W-1:0] timer;
  logic [3:0]         errQ;
  logic               toQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ      <= '0;
      timer      <= '0;
      errQ       <= '0;
      toQ        <= 1'b0;
      progVoltEn <= 1'b0;
    end else begin
      if (ctl.loadAddr) addrQ <= blockAddr;
      if (ctl.clearFlags)       timer <= '0;
      else if (timer != LIMIT_V) timer <= timer + 1'b1;
      if (ctl.clearFlags) begin
        errQ <= '0;
        toQ  <= 1'b0;
      end else if (ctl.captureStatus) begin
        errQ <= {busRdata[BIT_ERASE], busRdata[BIT_PROG],
                 busRdata[BIT_VOLT], busRdata[BIT_LOCK]};
        toQ  <= ctl.flagTimeout;
      end
      if (ctl.pvOn)       progVoltEn <= 1'b1;
      else if (ctl.pvOff) progVoltEn <= 1'b0;
    end
  end

  always_comb begin
    case (ctl.op)
      OP_ERASE:   busWdata = DATA_W'(CMD_ERASE);
      OP_CONFIRM: busWdata = DATA_W'(CMD_CONFIRM);
      OP_CLEAR:   busWdata = DATA_W'(CMD_CLEAR);
      default:    busWdata = DATA_W'(CMD_READARRAY);
    endcase
  end

  assign busAddr      = addrQ;
  assign statusReady  = busRdata[BIT_READY];
  assign timerExpired = (timer == LIMIT_V);
  assign errLock      = errQ[0];
  assign errVolt      = errQ[1];
  assign errProg      = errQ[2];
  assign errErase     = errQ[3];
  assign errTimeout   = toQ;

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 8,
  parameter int CYC_PER_MS = 100000,
  parameter int TIMEOUT_MS = 1500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] blockAddr,
  output logic              busy,
  output logic              done,
  output logic              errLock,
  output logic              errVolt,
  output logic              errProg,
  output logic              errErase,
  output logic              errTimeout,
  output logic              progVoltEn,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWe,
  output logic              busRe,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata
);

  seqCtl_t ctl;
  logic    statusReady;
  logic    timerExpired;

  erase_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .statusReady(statusReady), .timerExpired(timerExpired),
    .ctl(ctl), .busWe(busWe), .busRe(busRe), .busy(busy), .done(done)
  );

  erase_seq_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CYC_PER_MS(CYC_PER_MS), .TIMEOUT_MS(TIMEOUT_MS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .blockAddr(blockAddr),
    .busRdata(busRdata), .busAddr(busAddr), .busWdata(busWdata),
    .progVoltEn(progVoltEn), .statusReady(statusReady),
    .timerExpired(timerExpired), .errLock(errLock), .errVolt(errVolt),
    .errProg(errProg), .errErase(errErase), .errTimeout(errTimeout)
  );

endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              progVoltEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic              busRe,
  input logic [DATA_W-1:0] busWdata
);

  // R8
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busRe));

  // R8
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(busWe || busRe));

  // R2
  erase_pv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && (busWdata == DATA_W'(8'h20) || busWdata == DATA_W'(8'hD0))) |-> progVoltEn);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !done) |=> busy);

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(busAddr));

endmodule

bind flash_erase_seq flash_erase_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .progVoltEn(progVoltEn), .busAddr(busAddr), .busWe(busWe),
  .busRe(busRe), .busWdata(busWdata)
);

// File: tb/flash_erase_seq_bench.sv
module flash_erase_seq_bench;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int CPM    = 4;
  localparam int TMS    = 5;
  localparam int LIMIT  = CPM * TMS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] blockAddr = '0;
  logic busy, done, errLock, errVolt, errProg, errErase, errTimeout, progVoltEn;
  logic [ADDR_W-1:0] busAddr;
  logic busWe, busRe;
  logic [DATA_W-1:0] busWdata;
  logic [DATA_W-1:0] busRdata = '0;

  always #5 clk = ~clk;

  flash_erase_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYC_PER_MS(CPM), .TIMEOUT_MS(TMS))
  u_flash_erase_seq (
    .clk(clk), .rstN(rstN), .start(start), .blockAddr(blockAddr), .busy(busy),
    .done(done), .errLock(errLock), .errVolt(errVolt), .errProg(errProg),
    .errErase(errErase), .errTimeout(errTimeout), .progVoltEn(progVoltEn),
    .busAddr(busAddr), .busWe(busWe), .busRe(busRe), .busWdata(busWdata),
    .busRdata(busRdata)
  );

  int tests = 0;
  int fails = 0;

  // flash model and bus logger
  int readyAfter = 0;
  logic [6:0] statBits = '0;
  int rdCnt = 0;
  int rdAddrBad = 0;
  int wrCnt = 0;
  int busViol = 0;
  logic [ADDR_W-1:0] wrAddr [8];
  logic [DATA_W-1:0] wrData [8];
  logic              wrPv   [8];
  logic [ADDR_W-1:0] expAddr = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if ((busWe && busRe) || (!busy && (busWe || busRe))) busViol++;
      if (busWe) begin
        if (wrCnt < 8) begin
          wrAddr[wrCnt] = busAddr;
          wrData[wrCnt] = busWdata;
          wrPv[wrCnt]   = progVoltEn;
        end
        wrCnt++;
      end
      if (busRe) begin
        if (busAddr != expAddr) rdAddrBad++;
        busRdata <= {(rdCnt >= readyAfter), statBits};
        rdCnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Runs one erase; returns edge count until done seen (start edge = 1).
  task automatic runErase(input logic [ADDR_W-1:0] addr, input int rdy,
                          input logic [6:0] bits, input int injectAt,
                          output int n);
    readyAfter = rdy;
    statBits   = bits;
    rdCnt = 0; wrCnt = 0; rdAddrBad = 0; busViol = 0;
    expAddr = addr;
    @(negedge clk);
    start = 1'b1;
    blockAddr = addr;
    n = 0;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = 1'b0;
      blockAddr = addr ^ 16'h5A5A;
      if (n == 1) begin
        chk(busy && progVoltEn, "R2", "busy/pv after start", {busy, progVoltEn}, 2'b11);
        chk({errLock, errVolt, errProg, errErase, errTimeout} == 5'b0, "R5",
            "flags cleared on start",
            {errLock, errVolt, errProg, errErase, errTimeout}, 0);
      end
      if (n == injectAt) start = 1'b1;
      if (done) break;
      if (n > 2000) break;
    end
  endtask

  task automatic checkWrites(input string req);
    chk(wrCnt == 4, req, "write count", wrCnt, 4);
    if (wrCnt == 4) begin
      chk(wrData[0] == 8'h20 && wrPv[0], "R2", "first write", {wrPv[0], wrData[0]}, 9'h120);
      chk(wrData[1] == 8'hD0 && wrPv[1], "R2", "confirm write", {wrPv[1], wrData[1]}, 9'h1D0);
      chk(wrData[2] == 8'h50 && !wrPv[2], "R4", "clear write", {wrPv[2], wrData[2]}, 9'h050);
      chk(wrData[3] == 8'hFF && !wrPv[3], "R4", "read-array write", {wrPv[3], wrData[3]}, 9'h0FF);
      for (int i = 0; i < 4; i++)
        chk(wrAddr[i] == expAddr, "R2", "write address", wrAddr[i], expAddr);
    end
    chk(rdAddrBad == 0, "R3", "read address mismatches", rdAddrBad, 0);
    chk(busViol == 0, "R8", "bus strobe violations", busViol, 0);
  endtask

  task automatic testReset;
    chk({busy, done, progVoltEn, busWe, busRe} == 5'b0, "R1", "control outputs",
        {busy, done, progVoltEn, busWe, busRe}, 0);
    chk({errLock, errVolt, errProg, errErase, errTimeout} == 5'b0, "R1", "flags",
        {errLock, errVolt, errProg, errErase, errTimeout}, 0);
  endtask

  task automatic testReadyAt(input int k);
    int n;
    runErase(16'h1200 + 16'(k), k, 7'h00, 0, n);
    chk(n == 2 * k + 7, "R3", "done edge count", n, 2 * k + 7);
    chk(rdCnt == k + 1, "R3", "status reads", rdCnt, k + 1);
    chk(!busy && !progVoltEn, "R4", "idle at done", {busy, progVoltEn}, 0);
    checkWrites("R4");
    @(negedge clk);
    chk(!done, "R4", "done width", done, 0);
  endtask

  task automatic testError(input logic [6:0] bits);
    int n;
    logic [4:0] exp;
    exp = {bits[1], bits[3], bits[4], bits[5], 1'b0};
    runErase(16'h3400, 1, bits, 0, n);
    chk({errLock, errVolt, errProg, errErase, errTimeout} == exp, "R5", "flag decode",
        {errLock, errVolt, errProg, errErase, errTimeout}, exp);
    repeat (4) @(negedge clk);
    chk({errLock, errVolt, errProg, errErase, errTimeout} == exp, "R5", "flags held",
        {errLock, errVolt, errProg, errErase, errTimeout}, exp);
  endtask

  task automatic testTimeout;
    int n;
    runErase(16'h7700, 100000, 7'h00, 0, n);
    chk(errTimeout, "R6", "timeout flag", errTimeout, 1);
    chk({errLock, errVolt, errProg, errErase} == 4'b0, "R6", "no status errors",
        {errLock, errVolt, errProg, errErase}, 0);
    chk(n > LIMIT && n <= LIMIT + 10, "R6", "timeout done edge", n, LIMIT + 5);
    checkWrites("R6");
  endtask

  task automatic testStartWhileBusy;
    int n;
    runErase(16'h0ABC, 2, 7'h00, 5, n);
    chk(n == 11, "R7", "timing with ignored start", n, 11);
    checkWrites("R7");
    repeat (3) @(negedge clk);
    chk(!busy, "R7", "no restart after ignored start", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadyAt(0);
    testReadyAt(3);
    testError(7'h02);
    testError(7'h08);
    testError(7'h10);
    testError(7'h20);
    testError(7'h3A);
    testTimeout();
    testStartWhileBusy();
    testReadyAt(1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule